// File: doc/BRIEF.md
# Flexible Second-Operand Shifter

This block turns the second-operand part of a 32-bit data-processing instruction into a ready operand value and a shifter carry. It reads the instruction word, the value of the operand register, the low byte of the shift-amount register and the current carry flag. It returns the shifted operand, the carry that the shift produces, and a flag that marks a register-shift encoding as undefined. The block is purely combinational, so all three outputs follow the inputs within the same cycle.

The operand comes from one of three sources:

- **Rotated immediate.** An 8-bit constant is rotated right by an even amount.
- **Immediate shift.** The register value is shifted by a 5-bit amount held in the instruction.
- **Register shift.** The register value is shifted by the amount in the low byte of a second register.

A zero amount field in an immediate shift is not a plain zero-length shift for every type. For a right shift it means a full 32-position shift. For a rotate it means a one-position rotate that takes in the carry flag. A decoder resolves these cases into one shift command before the datapath sees them. The datapath is built around a single right rotator.

Top module: `flex_operand_unit`

## Requirements
- R1: When insn[25]=1, the operand is insn[7:0], zero-extended and rotated right by 2*insn[11:8]. The carry out equals the carry in when insn[11:8]=0. Otherwise it equals bit 31 of the operand.
- R2: When insn[25]=0 and insn[4]=0, the register value is shifted by insn[11:7] using the type in insn[6:5] (00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right). When the amount is nonzero, the carry out is the last bit shifted out.
- R3: An immediate shift-left with amount field 0 passes the register value unchanged, and the carry out equals the carry in.
- R4: An immediate logical-right or arithmetic-right shift with amount field 0 shifts by 32. Logical right gives 0 and arithmetic right gives 32 copies of bit 31. In both cases the carry out is register bit 31.
- R5: An immediate rotate-right with amount field 0 gives {carry_in, register[31:1]}, and the carry out is register bit 0.
- R6: When insn[25]=0 and insn[4]=1, the shift amount is rs_lo[7:0] and the type comes from insn[6:5]. Amounts 1 to 31 act as in R2. Amount 0 passes the register value unchanged, with the carry out equal to the carry in.
- R7: A register-specified shift-left or logical-right by exactly 32 gives 0. The carry out is register bit 0 for a left shift and register bit 31 for a right shift. An amount above 32 gives 0 with carry out 0.
- R8: An arithmetic-right shift by 32 or more, whether register-specified or implied as in R4, gives 32 copies of register bit 31, and that bit is also the carry out.
- R9: A register-specified rotate-right uses the amount modulo 32. When the amount is nonzero, the carry out is bit 31 of the result, so a nonzero multiple of 32 returns the register value with carry out equal to register bit 31.
- R10: undef_o is 1 exactly when insn[25]=0, insn[4]=1 and insn[7]=1. It is 0 for every other encoding, including immediates and immediate shifts with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word holding the operand fields |
| rm_val_i | input | DATA_W | Value of the operand register |
| rs_lo_i | input | RS_W | Low byte of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | DATA_W | Resulting second operand |
| carry_o | output | 1 | Carry produced by the shifter |
| undef_o | output | 1 | Register-shift encoding with its must-be-zero bit set |

## Verification
The bench builds the block with DATA_W=32, RS_W=8 and the staged rotator (LOG_STAGES=1). With these values every register-specified amount from 0 to 255 can be applied, which reaches the cases beyond the width: amounts of 33, 64 and 255, and rotates that wrap to a zero rotation. The rotated-immediate path is covered with all 16 rotate-field values. Each shift type is driven at amounts 0, 1, 31, 32 and 33, next to random instruction words whose expected operand is computed one bit step at a time.

// File: rtl/fop_pkg.sv
package fop_pkg;

   // Shift kind as carried by the two type bits of the instruction.
   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } sh_kind_e;

   // Resolved shift command handed from the decoder to the datapath.
   typedef struct packed {
      sh_kind_e kind;
      logic     rrx;
      logic     use_imm;
   } sh_cmd_t;

   // Instruction field layout (positions are decoded by neighbours).
   localparam int INSN_W        = 32;
   localparam int IMM_FLAG_BIT  = 25;
   localparam int REG_AMT_BIT   = 4;
   localparam int MBZ_BIT       = 7;
   localparam int ROT_LSB       = 8;
   localparam int ROT_MSB       = 11;
   localparam int AMT_LSB       = 7;
   localparam int AMT_MSB       = 11;
   localparam int KIND_LSB      = 5;
   localparam int IMM8_MSB      = 7;
   localparam int NARROW_AMT_W  = AMT_MSB - AMT_LSB + 1;
   localparam int ROT_FIELD_W   = ROT_MSB - ROT_LSB + 1;

   // Shift length implied by a zero amount field on right shifts.
   localparam int LONG_SHIFT    = 32;

endpackage

// File: rtl/fop_decode.sv
module fop_decode
   import fop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RS_W   = 8
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic [RS_W-1:0]   rs_lo_i,
   output sh_cmd_t           cmd_o,
   output logic [RS_W-1:0]   amt_o,
   output logic              undef_o
);

   localparam int MIN_RS_W = $clog2(LONG_SHIFT) + 1;

   generate
      if (RS_W < MIN_RS_W) begin : g_bad_rs_w
         $error("fop_decode: RS_W too narrow to hold a long shift");
      end
   endgenerate

   logic [NARROW_AMT_W-1:0] amt_field;
   logic [ROT_FIELD_W-1:0]  rot_field;
   logic                    by_register;
   sh_kind_e                field_kind;

   always_comb begin
      amt_field   = insn_i[AMT_MSB:AMT_LSB];
      rot_field   = insn_i[ROT_MSB:ROT_LSB];
      field_kind  = sh_kind_e'(insn_i[KIND_LSB+1:KIND_LSB]);
      by_register = !insn_i[IMM_FLAG_BIT] && insn_i[REG_AMT_BIT];

      cmd_o.use_imm = insn_i[IMM_FLAG_BIT];
      cmd_o.kind    = field_kind;
      cmd_o.rrx     = 1'b0;
      amt_o         = '0;

      if (insn_i[IMM_FLAG_BIT]) begin
         // even rotate of the 8-bit constant
         cmd_o.kind = SH_ROR;
         amt_o      = RS_W'({rot_field, 1'b0});
      end else if (by_register) begin
         amt_o = rs_lo_i;
      end else if (amt_field != '0) begin
         amt_o = RS_W'(amt_field);
      end else begin
         // zero-length field: meaning depends on the shift kind
         unique case (field_kind)
            SH_LSL:         amt_o = '0;
            SH_LSR, SH_ASR: amt_o = RS_W'(LONG_SHIFT);
            default: begin
               cmd_o.rrx = 1'b1;
               amt_o     = RS_W'(1);
            end
         endcase
      end

      undef_o = by_register && insn_i[MBZ_BIT];
   end

endmodule

// File: rtl/fop_rotator.sv
module fop_rotator #(
   parameter int W          = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int LG        = $clog2(W)
) (
   input  logic [W-1:0]  val_i,
   input  logic [LG-1:0] amt_i,
   output logic [W-1:0]  val_o
);

   generate
      if (LOG_STAGES) begin : g_log
         // one conditional rotate per amount bit
         logic [LG:0][W-1:0] stage;
         assign stage[0] = val_i;
         for (genvar s = 0; s < LG; s++) begin : g_st
            localparam int STEP = 1 << s;
            assign stage[s+1] = amt_i[s]
                              ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
                              : stage[s];
         end
         assign val_o = stage[LG];
      end else begin : g_flat
         // doubled word shifted once, low half kept
         logic [2*W-1:0] doubled;
         assign doubled = {val_i, val_i} >> amt_i;
         assign val_o   = doubled[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/fop_shifter.sv
module fop_shifter
   import fop_pkg::*;
#(
   parameter int W          = 32,
   parameter int RS_W       = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [W-1:0]    src_i,
   input  sh_cmd_t         cmd_i,
   input  logic [RS_W-1:0] amt_i,
   input  logic            carry_i,
   output logic [W-1:0]    res_o,
   output logic            carry_o
);

   localparam int LG = $clog2(W);

   generate
      if (RS_W < LG + 1) begin : g_bad_amt
         $error("fop_shifter: RS_W cannot express a full-width shift");
      end
   endgenerate

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   logic [W-1:0] pre_rot;
   logic [W-1:0] rotated;
   logic [W-1:0] keep_mask;
   logic [W-1:0] right_line;
   logic         is_left;
   logic         amt_zero;
   logic         amt_reach;
   logic         fill_bit;

   // a left shift is a right shift of the bit-reversed word
   assign is_left = (cmd_i.kind == SH_LSL);
   assign pre_rot = is_left ? flip(src_i) : src_i;

   fop_rotator #(
      .W          (W),
      .LOG_STAGES (LOG_STAGES)
   ) u_rot (
      .val_i (pre_rot),
      .amt_i (amt_i[LG-1:0]),
      .val_o (rotated)
   );

   always_comb begin
      amt_zero   = (amt_i == '0);
      amt_reach  = (amt_i <= RS_W'(W));
      keep_mask  = {W{1'b1}} >> amt_i;
      fill_bit   = (cmd_i.kind == SH_ASR) && src_i[W-1];
      right_line = (rotated & keep_mask) | (~keep_mask & {W{fill_bit}});

      if (cmd_i.kind == SH_ROR) begin
         res_o   = cmd_i.rrx ? {carry_i, rotated[W-2:0]} : rotated;
         carry_o = amt_zero ? carry_i : rotated[W-1];
      end else if (amt_zero) begin
         res_o   = src_i;
         carry_o = carry_i;
      end else begin
         res_o = is_left ? flip(right_line) : right_line;
         if (amt_reach)
            carry_o = rotated[W-1];
         else
            carry_o = fill_bit;
      end
   end

   always_comb begin
      if (cmd_i.kind == SH_ASR && amt_i >= RS_W'(W)) begin
         // R8
         asr_saturate_chk: assert (res_o == {W{src_i[W-1]}} && carry_o == src_i[W-1]);
      end
   end

endmodule

// File: rtl/flex_operand_unit.sv
module flex_operand_unit
   import fop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int RS_W       = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic [DATA_W-1:0] rm_val_i,
   input  logic [RS_W-1:0]   rs_lo_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] operand_o,
   output logic              carry_o,
   output logic              undef_o
);

   localparam int LG = $clog2(DATA_W);

   generate
      if (DATA_W < LONG_SHIFT || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("flex_operand_unit: DATA_W must be a power of two of at least 32");
      end
   endgenerate

   sh_cmd_t             cmd;
   logic [RS_W-1:0]     amt;
   logic [DATA_W-1:0]   src;

   fop_decode #(
      .DATA_W (DATA_W),
      .RS_W   (RS_W)
   ) u_dec (
      .insn_i  (insn_i),
      .rs_lo_i (rs_lo_i),
      .cmd_o   (cmd),
      .amt_o   (amt),
      .undef_o (undef_o)
   );

   assign src = cmd.use_imm ? DATA_W'(insn_i[IMM8_MSB:0]) : rm_val_i;

   fop_shifter #(
      .W          (DATA_W),
      .RS_W       (RS_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_sh (
      .src_i   (src),
      .cmd_i   (cmd),
      .amt_i   (amt),
      .carry_i (carry_i),
      .res_o   (operand_o),
      .carry_o (carry_o)
   );

   always_comb begin
      if (insn_i[IMM_FLAG_BIT] && insn_i[ROT_MSB:ROT_LSB] == '0) begin
         // R1
         imm_norot_chk: assert (operand_o == DATA_W'(insn_i[IMM8_MSB:0]) && carry_o == carry_i);
      end
      if (!insn_i[IMM_FLAG_BIT] && !insn_i[REG_AMT_BIT] &&
          insn_i[AMT_MSB:AMT_LSB] == '0 && insn_i[KIND_LSB+1:KIND_LSB] == 2'b11) begin
         // R5
         rrx_fill_chk: assert (operand_o[DATA_W-1] == carry_i && carry_o == rm_val_i[0]);
      end
      if (!insn_i[IMM_FLAG_BIT] && insn_i[REG_AMT_BIT] && rs_lo_i == '0) begin
         // R6
         reg_zero_pass_chk: assert (operand_o == rm_val_i && carry_o == carry_i);
      end
      if (!insn_i[IMM_FLAG_BIT] && insn_i[REG_AMT_BIT] && insn_i[KIND_LSB+1:KIND_LSB] == 2'b11 &&
          rs_lo_i != '0 && rs_lo_i[LG-1:0] == '0) begin
         // R9
         ror_wrap_chk: assert (operand_o == rm_val_i && carry_o == rm_val_i[DATA_W-1]);
      end
      if (!insn_i[IMM_FLAG_BIT] && !insn_i[REG_AMT_BIT] &&
          insn_i[AMT_MSB:AMT_LSB] == '0 && insn_i[KIND_LSB+1:KIND_LSB] == 2'b01) begin
         // R4
         lsr_long_chk: assert (operand_o == '0 && carry_o == rm_val_i[DATA_W-1]);
      end
   end

endmodule

// File: tb/sim_flex_operand_unit.sv
`timescale 1ns/1ps
module sim_flex_operand_unit;

   localparam int W   = 32;
   localparam int RSW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0]    insn = '0;
   logic [W-1:0]   rm = '0;
   logic [RSW-1:0] rs = '0;
   logic           cin = 1'b0;
   logic [W-1:0]   op;
   logic           cout;
   logic           undef;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   flex_operand_unit #(.DATA_W(W), .RS_W(RSW), .LOG_STAGES(1'b1)) u0 (
      .insn_i    (insn),
      .rm_val_i  (rm),
      .rs_lo_i   (rs),
      .carry_i   (cin),
      .operand_o (op),
      .carry_o   (cout),
      .undef_o   (undef)
   );

   always @(posedge clk) begin
      if (!rst_n) cycles <= 0;
      else        cycles <= cycles + 1;
   end

   initial begin
      forever begin
         @(posedge clk);
         if (cycles > 150000) begin
            fails++;
            $display("FAIL WDOG: run hung actual=%0d expected<150000 cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   // Bit-serial model: {undef, carry, operand}
   function automatic logic [W+1:0] ref_eval(input logic [31:0] ins, input logic [W-1:0] a,
                                              input logic [RSW-1:0] s, input logic c);
      logic [W-1:0] v;
      logic cy;
      logic u;
      logic [1:0] t;
      int n;
      u  = !ins[25] && ins[4] && ins[7];
      cy = c;
      if (ins[25]) begin
         v = W'(ins[7:0]);
         n = 2 * int'(ins[11:8]);
         for (int i = 0; i < n; i++) begin
            cy = v[0];
            v  = {v[0], v[W-1:1]};
         end
      end else begin
         v = a;
         t = ins[6:5];
         n = ins[4] ? int'(s) : int'(ins[11:7]);
         if (!ins[4] && n == 0 && t == 2'b11) begin
            cy = a[0];
            v  = {c, a[W-1:1]};
         end else begin
            if (!ins[4] && n == 0 && (t == 2'b01 || t == 2'b10)) n = 32;
            for (int i = 0; i < n; i++) begin
               case (t)
                  2'b00: begin cy = v[W-1]; v = {v[W-2:0], 1'b0}; end
                  2'b01: begin cy = v[0];   v = {1'b0, v[W-1:1]}; end
                  2'b10: begin cy = v[0];   v = {v[W-1], v[W-1:1]}; end
                  default: begin cy = v[0]; v = {v[0], v[W-1:1]}; end
               endcase
            end
         end
      end
      return {u, cy, v};
   endfunction

   function automatic logic [31:0] mk_imm(input int rot, input logic [7:0] k);
      return (32'd1 << 25) | (32'(rot) << 8) | 32'(k);
   endfunction

   function automatic logic [31:0] mk_ishift(input int amt, input int kind);
      return (32'(amt) << 7) | (32'(kind) << 5) | 32'h0000_000C;
   endfunction

   function automatic logic [31:0] mk_rshift(input int kind);
      return (32'(kind) << 5) | (32'd1 << 4) | 32'h0000_0A03;
   endfunction

   task automatic apply(input logic [31:0] ins, input logic [W-1:0] a, input logic [RSW-1:0] s,
                        input logic c, input string tag);
      logic [W+1:0] exp_v;
      logic [W+1:0] got_v;
      @(negedge clk);
      insn = ins; rm = a; rs = s; cin = c;
      #1;
      exp_v = ref_eval(ins, a, s, c);
      got_v = {undef, cout, op};
      checks++;
      if (got_v !== exp_v) begin
         fails++;
         $display("FAIL %s insn=%h rm=%h rs=%0d cin=%b actual={u,c,op}=%h expected=%h",
                  tag, ins, a, s, c, got_v, exp_v);
      end
   endtask

   initial begin
      logic [W-1:0] pat [4];
      int amts [5];
      string tg;
      void'($urandom(32'd20240611));
      pat[0] = 32'h8000_0001; pat[1] = 32'h7F3C_A5E6;
      pat[2] = 32'hF0F0_1234; pat[3] = 32'h0000_0000;
      amts[0] = 0; amts[1] = 1; amts[2] = 31; amts[3] = 32; amts[4] = 33;

      // reset state: all-zero inputs give zero outputs (LSL #0 of zero)
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({undef, cout, op} !== '0) begin
         fails++;
         $display("FAIL R3 reset state actual=%h expected=0", {undef, cout, op});
      end
      rst_n = 1'b1;

      // R1: all sixteen rotations, both carry values
      for (int r = 0; r < 16; r++) begin
         apply(mk_imm(r, 8'hC3), pat[1], 8'd0, r[0], "R1");
         apply(mk_imm(r, 8'h81), pat[2], 8'd0, ~r[0], "R1");
      end

      // R2: immediate shifts by 1 and 31
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < 3; p++) begin
            apply(mk_ishift(1, k), pat[p], 8'd0, 1'b0, "R2");
            apply(mk_ishift(31, k), pat[p], 8'd0, 1'b1, "R2");
         end

      // zero amount field per kind
      for (int p = 0; p < 4; p++) begin
         apply(mk_ishift(0, 0), pat[p], 8'd0, 1'b1, "R3");
         apply(mk_ishift(0, 1), pat[p], 8'd0, 1'b0, "R4");
         apply(mk_ishift(0, 2), pat[p], 8'd0, 1'b0, "R4");
         apply(mk_ishift(0, 2), pat[p], 8'd0, 1'b0, "R8");
         apply(mk_ishift(0, 3), pat[p], 8'd0, 1'b0, "R5");
         apply(mk_ishift(0, 3), pat[p], 8'd0, 1'b1, "R5");
      end

      // register shifts at 0, 1, 31, 32, 33 for every kind
      for (int k = 0; k < 4; k++)
         for (int j = 0; j < 5; j++)
            for (int p = 0; p < 3; p++) begin
               if (amts[j] == 0)                 tg = "R6";
               else if (amts[j] < 32)            tg = "R6";
               else if (k == 2)                  tg = "R8";
               else if (k == 3)                  tg = "R9";
               else                              tg = "R7";
               apply(mk_rshift(k), pat[p], RSW'(amts[j]), p[0], tg);
            end

      // wide amounts
      apply(mk_rshift(3), pat[1], 8'd64, 1'b0, "R9");
      apply(mk_rshift(3), pat[0], 8'd255, 1'b0, "R9");
      apply(mk_rshift(1), pat[0], 8'd255, 1'b1, "R7");
      apply(mk_rshift(0), pat[0], 8'd200, 1'b1, "R7");
      apply(mk_rshift(2), pat[0], 8'd255, 1'b0, "R8");
      apply(mk_rshift(2), pat[1], 8'd128, 1'b1, "R8");

      // undefined flag and its look-alikes
      for (int k = 0; k < 4; k++)
         apply(mk_rshift(k) | 32'h80, pat[2], 8'd5, 1'b0, "R10");
      apply(mk_imm(3, 8'hF0), pat[2], 8'd5, 1'b0, "R10");
      apply(mk_ishift(3, 1), pat[2], 8'd5, 1'b0, "R10");

      // random instruction words
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] ri;
         logic [RSW-1:0] rr;
         ri = $urandom;
         rr = ($urandom % 2 == 0) ? RSW'($urandom % 40) : RSW'($urandom);
         apply(ri, W'($urandom), rr, 1'($urandom), "R2");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule